// File: doc/BRIEF.md
# Fractional Clock Gear with Deferred Ratio Update

This block produces a clock-enable pulse train whose average rate is a programmable fraction M/32 of the clock it runs on, with M anywhere from 1 to 32. It works by pulse swallowing. In each 32-cycle window, an accumulator adds M on every cycle. The enable is raised on every cycle where that sum reaches or passes the window size. As a result, exactly M of the 32 cycles pass, and they are spread as evenly as the integer grid allows. Logic downstream qualifies its registers with the enable, so it runs at the reduced rate without a second clock.

Software sees two registers on a simple bus with write strobe, read strobe, address and data. A frequency-control register holds a 5-bit gear field. The field stores 32 minus M, so the value zero means full rate. A separate update register holds a request bit. Writing the gear field has no effect on the running ratio. Setting the request bit captures the field as the pending ratio. Hardware then installs the pending ratio at the next window boundary and clears the request bit in that same cycle. Software polls the request bit to learn that the change is complete.

Top module: `clk_gear_top`

## Requirements
- R1: A synchronous reset clears both registers, the request bit, the read data and the enable. After reset the running gear field is 0 (full rate), and the first clock after reset release is cycle 0 of a window.
- R2: While a gear field F is in force, every 32 consecutive clocks carry exactly 32−F enable pulses. Field 0 gives an enable on every clock.
- R3: In window cycle k (0..31) with multiplier M = 32−F, the enable is raised one clock later exactly when ((k·M) mod 32) + M ≥ 32.
- R4: Writing the frequency-control register (address 0xE0, gear field in bits 12:8) never changes the running ratio by itself.
- R5: A write to the update register (address 0x04) with bit 31 set, while the request bit is clear, sets the request bit. The same write captures the gear field that the frequency-control register held before that write.
- R6: The pending field is installed only on the clock that ends window cycle 31. The request bit clears on that same clock, so the new ratio governs the whole following window.
- R7: While the request bit is set, writes that set it are ignored and do not recapture the field. Frequency-control writes during that time do not alter the pending field.
- R8: Reads return data one clock after the read strobe, and 0 on clocks without a read strobe. The frequency-control register returns all 32 bits as written. The update register returns bits 30:0 as written and the live request bit in bit 31. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that the enable is derived from |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| clk_en | output | 1 | Registered fractional clock enable |

## Verification
The bench builds the block with its default parameters: a 5-bit gear field, a 32-cycle window and 32-bit registers. At these values all 32 ratios can be swept, each through a full request-and-install handshake, in a few thousand cycles. A behavioural model predicts the enable from the window position and the ratio in force, and predicts the read data, on every clock. The directed sequences then count pulses per window for each field value. They measure how long the request bit stays set, try to re-arm the request and overwrite the gear field while a change is pending, and apply a reset while a change is pending.

// File: rtl/clk_gear_pkg.sv
package clk_gear_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FREQ = 2'd1,
    SEL_UPD  = 2'd2
  } gear_sel_e;

endpackage

// File: rtl/clk_gear_regs.sv
module clk_gear_regs
  import clk_gear_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 5,
  parameter int FIELD_LSB = 8,
  parameter int REQ_BIT   = 31,
  parameter logic [ADDR_W-1:0] FREQ_ADDR = 12'h0E0,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 12'h004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              install,
  output logic [DATA_W-1:0] rdata,
  output logic              req,
  output logic [FRAC_W-1:0] pend_field
);

  localparam logic [DATA_W-1:0] REQ_MASK = DATA_W'(1) << REQ_BIT;

  logic [DATA_W-1:0] freq_q;
  logic [DATA_W-1:0] upd_rest_q;
  logic [DATA_W-1:0] upd_view;
  logic [DATA_W-1:0] rd_mux;
  gear_sel_e         sel;

  always_comb begin
    if (addr == FREQ_ADDR)      sel = SEL_FREQ;
    else if (addr == UPD_ADDR)  sel = SEL_UPD;
    else                        sel = SEL_NONE;
  end

  assign upd_view = upd_rest_q | (req ? REQ_MASK : '0);

  always_comb begin
    case (sel)
      SEL_FREQ: rd_mux = freq_q;
      SEL_UPD:  rd_mux = upd_view;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q     <= '0;
      upd_rest_q <= '0;
      req        <= 1'b0;
      pend_field <= '0;
      rdata      <= '0;
    end else begin
      rdata <= rd_en ? rd_mux : '0;
      if (wr_en && sel == SEL_FREQ) begin
        freq_q <= wdata;
      end
      if (wr_en && sel == SEL_UPD) begin
        upd_rest_q <= wdata & ~REQ_MASK;
      end
      if (install) begin
        req <= 1'b0;
      end else if (wr_en && sel == SEL_UPD && wdata[REQ_BIT] && !req) begin
        req        <= 1'b1;
        pend_field <= freq_q[FIELD_LSB +: FRAC_W];
      end
    end
  end

endmodule

// File: rtl/clk_gear_window.sv
module clk_gear_window #(
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [FRAC_W-1:0] pend_field,
  output logic              win_first,
  output logic              win_last,
  output logic              install,
  output logic [FRAC_W-1:0] active_field
);

  logic [FRAC_W-1:0] pos_q;

  assign win_first = (pos_q == '0);
  assign win_last  = (pos_q == '1);
  assign install   = req && win_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q        <= '0;
      active_field <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
      if (install) begin
        active_field <= pend_field;
      end
    end
  end

endmodule

// File: rtl/clk_gear_accum.sv
module clk_gear_accum #(
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_first,
  input  logic [FRAC_W-1:0] active_field,
  output logic              clk_en
);

  localparam int WIN = 1 << FRAC_W;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] base;
  logic [FRAC_W:0]   mult;
  logic [FRAC_W:0]   sum;

  assign base = win_first ? '0 : acc_q;
  assign mult = (FRAC_W+1)'(WIN) - {1'b0, active_field};
  assign sum  = {1'b0, base} + mult;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      clk_en <= 1'b0;
    end else begin
      acc_q  <= sum[FRAC_W-1:0];
      clk_en <= sum[FRAC_W];
    end
  end

endmodule

// File: rtl/clk_gear_top.sv
module clk_gear_top #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 5,
  parameter int FIELD_LSB = 8,
  parameter int REQ_BIT   = 31,
  parameter logic [ADDR_W-1:0] FREQ_ADDR = 12'h0E0,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 12'h004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              clk_en
);

  logic              req_live;
  logic              install;
  logic              win_first;
  logic              win_last;
  logic [FRAC_W-1:0] pend_field;
  logic [FRAC_W-1:0] active_field;

  clk_gear_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W),
    .FIELD_LSB(FIELD_LSB), .REQ_BIT(REQ_BIT),
    .FREQ_ADDR(FREQ_ADDR), .UPD_ADDR(UPD_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .install(install), .rdata(rdata), .req(req_live),
    .pend_field(pend_field)
  );

  clk_gear_window #(.FRAC_W(FRAC_W)) u_window (
    .clk(clk), .rst(rst), .req(req_live), .pend_field(pend_field),
    .win_first(win_first), .win_last(win_last), .install(install),
    .active_field(active_field)
  );

  clk_gear_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .win_first(win_first),
    .active_field(active_field), .clk_en(clk_en)
  );

endmodule

// File: rtl/clk_gear_chk.sv
module clk_gear_chk #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              clk_en,
  input logic              req_live,
  input logic              win_last,
  input logic [FRAC_W-1:0] active_field
);

  AST_REQ_DROP_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(req_live) |-> $past(win_last)); // R6

  AST_RATIO_HELD_MIDWIN: assert property (@(posedge clk) disable iff (rst)
    !$past(win_last) |-> $stable(active_field)); // R6

  AST_NO_REQ_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !$past(req_live) |-> $stable(active_field)); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_live && !win_last) |=> req_live); // R5

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (active_field == '0) |=> clk_en); // R2

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0)); // R8

endmodule

bind clk_gear_top clk_gear_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rdata(rdata), .clk_en(clk_en),
  .req_live(req_live), .win_last(win_last), .active_field(active_field)
);

// File: tb/clk_gear_top_tb.sv
module clk_gear_top_tb;

  localparam logic [11:0] A_FREQ = 12'h0E0;
  localparam logic [11:0] A_UPD  = 12'h004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clk_en;

  int total = 0;
  int bad   = 0;

  clk_gear_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_en(clk_en)
  );

  always #4 clk = ~clk;

  // behavioural reference model, advanced at each falling edge
  int          m_cnt, m_act, m_pend;
  bit          m_req, m_en, m_valid;
  logic [31:0] m_freq, m_rest, m_rd;

  initial begin
    m_valid = 0; m_cnt = 0; m_act = 0; m_pend = 0; m_req = 0; m_en = 0;
    m_freq = 0; m_rest = 0; m_rd = 0;
  end

  always @(negedge clk) begin
    int mult, accb, n_cnt, n_act, n_pend;
    bit n_req, n_en;
    logic [31:0] n_freq, n_rest, n_rd;
    if (m_valid) begin
      total++;
      if (clk_en !== m_en) begin
        bad++;
        $display("FAIL R3 enable pattern: actual=%0b expected=%0b", clk_en, m_en);
      end
      total++;
      if (rdata !== m_rd) begin
        bad++;
        $display("FAIL R8 read data: actual=%h expected=%h", rdata, m_rd);
      end
    end
    if (rst) begin
      m_cnt = 0; m_act = 0; m_pend = 0; m_req = 0; m_en = 0;
      m_freq = 0; m_rest = 0; m_rd = 0; m_valid = 1;
    end else if (m_valid) begin
      mult  = 32 - m_act;
      accb  = (m_cnt * mult) % 32;
      n_en  = (accb + mult) >= 32;
      n_cnt = (m_cnt + 1) % 32;
      n_act = m_act; n_pend = m_pend; n_req = m_req;
      n_freq = m_freq; n_rest = m_rest;
      if (m_req && m_cnt == 31) begin
        n_act = m_pend;
        n_req = 0;
      end
      if (wr_en && addr == A_FREQ) n_freq = wdata;
      if (wr_en && addr == A_UPD) begin
        n_rest = {1'b0, wdata[30:0]};
        if (!m_req && wdata[31]) begin
          n_req  = 1;
          n_pend = int'(m_freq[12:8]);
        end
      end
      if (!rd_en)               n_rd = 0;
      else if (addr == A_FREQ)  n_rd = m_freq;
      else if (addr == A_UPD)   n_rd = {m_req, m_rest[30:0]};
      else                      n_rd = 0;
      m_cnt = n_cnt; m_act = n_act; m_pend = n_pend; m_req = n_req;
      m_en = n_en; m_freq = n_freq; m_rest = n_rest; m_rd = n_rd;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #2;
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      c += int'(clk_en);
    end
  endtask

  task automatic wait_done(output int lat);
    logic [31:0] d;
    lat = 0;
    do begin
      bus_rd(A_UPD, d);
      lat++;
    end while (d[31] && lat < 80);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int c, lat;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 enable in reset", {31'b0, clk_en}, 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    rst = 1'b0;
    bus_rd(A_FREQ, d); chk("R1 freq reg reset", d, 32'd0);
    bus_rd(A_UPD, d);  chk("R1 update reg reset", d, 32'd0);
    count_en(32, c);   chk("R1 full rate after reset", c, 32);

    // R4: field written without request keeps full rate
    bus_wr(A_FREQ, 32'h0000_1800);
    count_en(32, c);   chk("R4 no change without request", c, 32);
    bus_rd(A_FREQ, d); chk("R8 freq readback", d, 32'h0000_1800);

    // R5 / R6: request installs field 24 (multiplier 8)
    bus_wr(A_UPD, 32'h8000_1234);
    wait_done(lat);
    chk("R6 request cleared within a window", {31'b0, lat <= 34}, 32'd1);
    bus_rd(A_UPD, d);  chk("R8 update rest bits", d, 32'h0000_1234);
    idle(2);
    count_en(32, c);   chk("R2 multiplier 8", c, 8);

    // R7: re-arm and field overwrite while pending are ignored
    bus_wr(A_FREQ, 32'h0000_1000);
    idle(40);
    bus_wr(A_UPD, 32'h8000_0000);
    bus_wr(A_FREQ, 32'h0000_1F00);
    bus_wr(A_UPD, 32'h8000_0000);
    wait_done(lat);
    idle(2);
    count_en(32, c);   chk("R7 pending field kept", c, 16);
    bus_rd(A_FREQ, d); chk("R8 freq last write", d, 32'h0000_1F00);

    // R2 / R3: sweep every field value
    for (int f = 0; f < 32; f++) begin
      bus_wr(A_FREQ, 32'hA5A5_00C3 | (32'(f) << 8));
      bus_wr(A_UPD, 32'h8000_0000);
      wait_done(lat);
      chk("R6 sweep latency", {31'b0, lat <= 34}, 32'd1);
      idle(2);
      count_en(32, c);
      chk("R2 sweep pulse count", c, 32 - f);
    end

    bus_rd(12'h100, d); chk("R8 unmapped read", d, 32'd0);

    // R1: reset while a request is pending
    bus_wr(A_FREQ, 32'h0000_0800);
    bus_wr(A_UPD, 32'h8000_0000);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    bus_rd(A_UPD, d);  chk("R1 request cleared by reset", d, 32'd0);
    count_en(32, c);   chk("R1 full rate after mid reset", c, 32);
    idle(2);
    finish_run();
  end

endmodule